// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral on a simple synchronous register bus. A prescaler divides the system clock into a slow tick; a down-counter loaded from a programmable 6-bit tick count drops by one on each tick. When the count runs out the first time, the block records a status flag and can raise an interrupt-style event. The counter then reloads itself. If software still has not reloaded it when it runs out a second time, the block records a second flag and, if the reboot permission bit is set, drives a fixed-length pulse on its reset output.

Software keeps the watchdog quiet by writing the value 0x01 to the reload register before the count runs out. A halt bit freezes both the prescaler and the counter. The block leaves power-on reset halted. The status flags are sticky and only a write-one-to-clear access removes them. Because the block is reset only by its own power-on reset, the flags survive the system reset that it requests.

Top module: `dog_watch`

## Requirements
- R1: After power-on reset the control register (address 0) reads 0x01 (halt set, event enable clear), the timeout register (address 2) reads 50, the status register (address 3) and the configuration register (address 4) read 0, and both `wdEvent` and `wdReset` are low.
- R2: While running, the counter drops by one every `TICK_DIV` clock cycles. After a reload whose write is captured at clock edge E, status bit 0 (first expiry) becomes 1 right after edge E + T·`TICK_DIV`, where T is the programmed tick count. It is still 0 one cycle earlier.
- R3: A write to address 2 stores the whole byte (tick count in bits [5:0], spare bits [7:6] kept as written) and reads back unchanged. A write whose bits [5:0] are below 4 is ignored, and the previous byte is kept.
- R4: Writing exactly 0x01 to address 1 restarts the prescaler, the counter and the expiry stage from the programmed tick count. Any other value written there has no effect.
- R5: While control bit 0 (halt) is 1, the prescaler and the counter hold their values. When halt is cleared, counting resumes from where it stopped, so total running cycles to expiry stay T·`TICK_DIV`.
- R6: After the first expiry the counter reloads and counts again. The second expiry, T·`TICK_DIV` cycles later, sets status bit 1.
- R7: On the second expiry `wdReset` goes high for exactly `RST_CYCLES` cycles, but only if configuration bit 0 (reboot enable) is 1. When that bit is 0, `wdReset` stays low.
- R8: The status bits are sticky. Writing to address 3 clears each bit whose data bit is 1 and leaves the others. Bit 1 stays set after the reset pulse ends.
- R9: `wdEvent` is high while status bit 0 is 1 and control bit 1 (event enable) is 1. With event enable clear, `wdEvent` stays low, although status bit 0 is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | Write when 1, read when 0 |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from busAddr |
| wdEvent | output | 1 | First-expiry event, level until cleared |
| wdReset | output | 1 | Watchdog reset request pulse |

## Verification
The checker watches these rules on every cycle:
- the tick count never falls below 4;
- a halted counter holds its value;
- a reload loads the programmed count;
- every rise of the reset output has reboot enable behind it and a set second-expiry flag;
- the event only shows with its flag set;
- the second-expiry flag only falls on a clearing write.

Some properties need a long window, and only the bench scenarios can show them:
- the exact expiry cycles for several tick counts;
- the pulse length;
- the resumed count after a halt;
- that a reload value other than 0x01 is ignored;
- the full read-back sweep of the timeout register.

// File: rtl/dog_pkg.sv
package dog_pkg;
  parameter int unsigned TMR_W = 6;
  parameter int unsigned MIN_TICKS = 4;
  parameter int unsigned DEF_TICKS = 50;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_RELOAD = 3'd1;
  localparam logic [2:0] ADDR_TMR    = 3'd2;
  localparam logic [2:0] ADDR_STAT   = 3'd3;
  localparam logic [2:0] ADDR_CFG    = 3'd4;

  localparam logic [7:0] RELOAD_KEY = 8'h01;

  typedef struct packed {
    logic             reload;
    logic             halt;
    logic [TMR_W-1:0] limit;
  } dogCmd_t;
endpackage

// File: rtl/dog_count.sv
module dog_count
  import dog_pkg::*;
#(
  parameter int unsigned TICK_DIV = 30_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  dogCmd_t          cmd,
  output logic             expireFirst,
  output logic             expireSecond,
  output logic [TMR_W-1:0] cntVal
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic             stage;
  logic             tick;
  logic             expiry;

  assign tick   = (preCnt == PRE_LAST);
  assign expiry = tick && !cmd.halt && !cmd.reload && (cntVal <= TMR_W'(1));
  assign expireFirst  = expiry && !stage;
  assign expireSecond = expiry && stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cntVal <= TMR_W'(DEF_TICKS);
      stage  <= 1'b0;
    end else if (cmd.reload) begin
      preCnt <= '0;
      cntVal <= cmd.limit;
      stage  <= 1'b0;
    end else if (!cmd.halt) begin
      if (tick) begin
        preCnt <= '0;
        if (cntVal <= TMR_W'(1)) begin
          cntVal <= cmd.limit;
          stage  <= ~stage;
        end else begin
          cntVal <= cntVal - TMR_W'(1);
        end
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/dog_regs.sv
module dog_regs
  import dog_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWe,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       expireFirst,
  input  logic       expireSecond,
  output dogCmd_t    cmd,
  output logic [1:0] statusQ,
  output logic       eventEnQ,
  output logic       rebootEnQ,
  output logic       wdEvent,
  output logic       wdReset
);
  localparam int unsigned RST_W = $clog2(RST_CYCLES + 1);
  localparam int unsigned SPARE_W = 8 - TMR_W;

  logic               haltQ;
  logic [TMR_W-1:0]   limitQ;
  logic [SPARE_W-1:0] spareQ;
  logic [RST_W-1:0]   rstCnt;
  logic               wrEn;

  assign wrEn = busSel && busWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltQ     <= 1'b1;
      eventEnQ  <= 1'b0;
      rebootEnQ <= 1'b0;
      limitQ    <= TMR_W'(DEF_TICKS);
      spareQ    <= '0;
    end else if (wrEn) begin
      case (busAddr)
        ADDR_CTRL: begin
          haltQ    <= busWdata[0];
          eventEnQ <= busWdata[1];
        end
        ADDR_TMR: begin
          if (busWdata[TMR_W-1:0] >= TMR_W'(MIN_TICKS)) begin
            limitQ <= busWdata[TMR_W-1:0];
            spareQ <= busWdata[7:TMR_W];
          end
        end
        ADDR_CFG: rebootEnQ <= busWdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= 2'b00;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (wrEn && busAddr == ADDR_STAT && busWdata[b]) statusQ[b] <= 1'b0;
      end
      if (expireFirst)  statusQ[0] <= 1'b1;
      if (expireSecond) statusQ[1] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (expireSecond && rebootEnQ) begin
      rstCnt <= RST_W'(RST_CYCLES);
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - RST_W'(1);
    end
  end

  assign wdReset = (rstCnt != '0);
  assign wdEvent = statusQ[0] && eventEnQ;

  assign cmd.reload = wrEn && (busAddr == ADDR_RELOAD) && (busWdata == RELOAD_KEY);
  assign cmd.halt   = haltQ;
  assign cmd.limit  = limitQ;

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdata = {6'b0, eventEnQ, haltQ};
      ADDR_TMR:  busRdata = {spareQ, limitQ};
      ADDR_STAT: busRdata = {6'b0, statusQ};
      ADDR_CFG:  busRdata = {7'b0, rebootEnQ};
      default:   busRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/dog_watch.sv
module dog_watch
  import dog_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 30_000_000,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWe,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       wdEvent,
  output logic       wdReset
);
  dogCmd_t          cmd;
  logic             expireFirst;
  logic             expireSecond;
  logic [TMR_W-1:0] cntVal;
  logic [1:0]       statusQ;
  logic             eventEnQ;
  logic             rebootEnQ;

  dog_regs #(.RST_CYCLES(RST_CYCLES)) uRegs (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .expireFirst(expireFirst), .expireSecond(expireSecond),
    .cmd(cmd), .statusQ(statusQ), .eventEnQ(eventEnQ),
    .rebootEnQ(rebootEnQ), .wdEvent(wdEvent), .wdReset(wdReset)
  );

  dog_count #(.TICK_DIV(TICK_DIV)) uCount (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .expireFirst(expireFirst), .expireSecond(expireSecond),
    .cntVal(cntVal)
  );
endmodule

// File: rtl/dog_watch_chk.sv
module dog_watch_chk
  import dog_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWe,
  input logic [2:0]       busAddr,
  input logic [7:0]       busWdata,
  input logic             wdEvent,
  input logic             wdReset,
  input dogCmd_t          cmd,
  input logic             expireFirst,
  input logic [TMR_W-1:0] cntVal,
  input logic [1:0]       statusQ,
  input logic             rebootEnQ
);
  a_r3_limit_floor: assert property (@(posedge clk) disable iff (!rstN)
    cmd.limit >= TMR_W'(MIN_TICKS));

  a_r5_halt_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.halt && !cmd.reload) |=> $stable(cntVal));

  a_r4_reload_loads: assert property (@(posedge clk) disable iff (!rstN)
    cmd.reload |=> (cntVal == $past(cmd.limit)));

  a_r2_first_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    expireFirst |=> statusQ[0]);

  a_r7_reset_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdReset) |-> ($past(rebootEnQ) && statusQ[1]));

  a_r8_flag_cleared_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusQ[1]) |-> $past(busSel && busWe && busAddr == ADDR_STAT && busWdata[1]));

  a_r9_event_has_flag: assert property (@(posedge clk) disable iff (!rstN)
    wdEvent |-> statusQ[0]);
endmodule

bind dog_watch dog_watch_chk uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .wdEvent(wdEvent),
  .wdReset(wdReset), .cmd(cmd), .expireFirst(expireFirst),
  .cntVal(cntVal), .statusQ(statusQ), .rebootEnQ(rebootEnQ)
);

// File: tb/sim_dog_watch.sv
module sim_dog_watch;
  localparam int unsigned DIV = 4;
  localparam int unsigned RSTC = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWe = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       wdEvent;
  logic       wdReset;

  int cyc = 0;
  int wrEdge = 0;
  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dog_watch #(.TICK_DIV(DIV), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .wdEvent(wdEvent), .wdReset(wdReset)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
    wrEdge = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    busAddr = a;
    #1;
    v = int'(busRdata);
  endtask

  task automatic waitEdge(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hang expected completion");
    finishRun();
  end

  initial begin
    int v;
    int model;
    int e;
    int h;
    int u;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 8'h01);
    rd(3'd2, v); check("R1 timeout", v, 50);
    rd(3'd3, v); check("R1 status", v, 0);
    rd(3'd4, v); check("R1 config", v, 0);
    check("R1 event", int'(wdEvent), 0);
    check("R1 reset", int'(wdReset), 0);

    // R3 sweep of every tick count, spare bits set to 2'b10
    model = 50;
    for (int t = 0; t < 64; t++) begin
      wr(3'd2, 8'(t | 8'h80));
      if (t >= 4) model = t | 8'h80;
      rd(3'd2, v); check("R3 timeout write", v, model);
    end

    // R2 R6 R7 R8 R9 timing across several tick counts, reboot enabled
    wr(3'd4, 8'h01);
    for (int k = 0; k < 3; k++) begin
      int t;
      t = (k == 0) ? 4 : (k == 1) ? 5 : 7;
      wr(3'd0, 8'h03);
      wr(3'd2, 8'(t));
      wr(3'd3, 8'h03);
      wr(3'd0, 8'h02);
      wr(3'd1, 8'h01);
      e = wrEdge;
      waitEdge(e + t*DIV - 1);
      check("R2 before first expiry", int'(wdEvent), 0);
      waitEdge(e + t*DIV);
      check("R9 event at first expiry", int'(wdEvent), 1);
      rd(3'd3, v); check("R2 first flag", v, 1);
      waitEdge(e + 2*t*DIV - 1);
      rd(3'd3, v); check("R6 before second expiry", v, 1);
      check("R7 low before second expiry", int'(wdReset), 0);
      waitEdge(e + 2*t*DIV);
      rd(3'd3, v); check("R6 second flag", v, 3);
      check("R7 pulse start", int'(wdReset), 1);
      waitEdge(e + 2*t*DIV + RSTC - 1);
      check("R7 pulse last", int'(wdReset), 1);
      waitEdge(e + 2*t*DIV + RSTC);
      check("R7 pulse end", int'(wdReset), 0);
      rd(3'd3, v); check("R8 sticky after pulse", v, 3);
    end

    // R8 per-bit write-one-to-clear
    wr(3'd0, 8'h03);
    wr(3'd3, 8'h01);
    rd(3'd3, v); check("R8 clear bit0 only", v, 2);
    check("R9 event drops with flag", int'(wdEvent), 0);
    wr(3'd3, 8'h02);
    rd(3'd3, v); check("R8 clear bit1", v, 0);

    // R7 suppressed when reboot enable is clear
    wr(3'd4, 8'h00);
    wr(3'd2, 8'd4);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h01);
    e = wrEdge;
    for (int c = 2*4*DIV - 1; c <= 2*4*DIV + RSTC; c++) begin
      waitEdge(e + c);
      check("R7 suppressed", int'(wdReset), 0);
    end
    rd(3'd3, v); check("R6 flag without reboot", v, 3);

    // R9 event enable clear
    wr(3'd0, 8'h01);
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h01);
    e = wrEdge;
    waitEdge(e + 4*DIV);
    rd(3'd3, v); check("R9 flag set when disabled", v, 1);
    check("R9 event masked", int'(wdEvent), 0);

    // R5 halt and resume
    wr(3'd0, 8'h03);
    wr(3'd2, 8'd6);
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h01);
    e = wrEdge;
    waitEdge(e + 5);
    wr(3'd0, 8'h03);
    h = wrEdge;
    waitEdge(h + 200);
    rd(3'd3, v); check("R5 frozen while halted", v, 0);
    wr(3'd0, 8'h02);
    u = wrEdge;
    waitEdge(u + 6*DIV - (h - e) - 1);
    check("R5 resumed before expiry", int'(wdEvent), 0);
    waitEdge(u + 6*DIV - (h - e));
    check("R5 resumed expiry", int'(wdEvent), 1);

    // R4 wrong key ignored, right key restarts
    wr(3'd0, 8'h03);
    wr(3'd2, 8'd5);
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h01);
    e = wrEdge;
    waitEdge(e + 6);
    wr(3'd1, 8'h02);
    waitEdge(e + 5*DIV - 1);
    check("R4 wrong key before", int'(wdEvent), 0);
    waitEdge(e + 5*DIV);
    check("R4 wrong key ignored", int'(wdEvent), 1);
    wr(3'd3, 8'h03);
    wr(3'd1, 8'h01);
    e = wrEdge;
    waitEdge(e + 9);
    wr(3'd1, 8'h01);
    e = wrEdge;
    waitEdge(e + 5*DIV - 1);
    check("R4 restart before", int'(wdEvent), 0);
    waitEdge(e + 5*DIV);
    check("R4 restart expiry", int'(wdEvent), 1);

    finishRun();
  end
endmodule